// File: doc/BRIEF.md
# Prioritised interrupt request tracker

This block is the per-processor core of an interrupt controller. It keeps three bit vectors across the full vector space: requests waiting, vectors in service and the trigger mode of each vector. It also holds a task-priority value and a spurious-vector register with a software enable. From that state it derives a processor priority. It then drives a registered interrupt-pending signal towards the processor.

The processor takes an interrupt by pulsing acknowledge. One cycle later the block returns either the real vector or, when the best request is masked by task priority, the spurious vector. The processor finishes an interrupt with an end-of-interrupt pulse, which retires the highest vector in service. Interrupt sources pulse a set-request input with a vector and a trigger mode. A small select/word read port exposes all internal state. A synchronous init input returns the block to its power-up state, and so does the asynchronous reset.

Top module: `irq_prio_tracker`

## Requirements
- R1: After reset or an init pulse, the request, in-service and trigger vectors are all zero, task priority reads 0, the spurious register reads 0x0FF, and both irq_pending and ack_valid are low in the following cycle.
- R2: A set_req pulse sets the request bit of set_vec. It also sets that vector's trigger bit when set_level is 1, or clears it when set_level is 0.
- R3: The spurious register holds 9 bits. Bit 8 is the enable. While bit 8 is 0, irq_pending is 0 and an acknowledge yields ack_valid low with no state change. Requests are still recorded.
- R4: A tpr_wr pulse stores tpr_nib shifted left by 4 as the task priority. The low nibble always reads 0.
- R5: Processor priority is computed from the class (bits 7:4) of the highest in-service vector, taken as class 0 when none is in service. If that class is at most the task-priority class, processor priority equals the task priority. Otherwise it equals that class with a zero low nibble.
- R6: irq_pending is registered. In each cycle it shows whether, in the previous cycle, the block was enabled, some request was set, and either processor priority was 0 or the top request's class exceeded the processor-priority class.
- R7: An acknowledge with the block enabled, when not masked (see R8), moves the highest request bit to in-service. In the next cycle it gives ack_valid high with ack_vec equal to that vector.
- R8: An acknowledge with the block enabled, task priority nonzero and the top request vector ≤ task priority gives ack_valid high with ack_vec equal to the spurious register's low 8 bits. Request and in-service state are left unchanged.
- R9: An acknowledge with no request set gives ack_valid low in the next cycle.
- R10: An eoi pulse clears the highest set in-service bit. With no in-service bit set it changes nothing.
- R11: In a single cycle, end-of-interrupt and acknowledge both act on the state as it was before that edge, with the acknowledge's in-service set taking effect after the eoi clear. A set_req of the acknowledged vector in the same cycle leaves its request bit set. init overrides every other input.
- R12: rd_data is combinational. rd_sel 0/1/2 returns request/in-service/trigger word rd_word, whose bit b is vector 32*rd_word+b. rd_sel 3 returns task priority, 4 returns processor priority, 5 returns the spurious register, and 6 or 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous return to power-up state |
| set_req | input | 1 | Record a request for set_vec |
| set_vec | input | 8 | Vector being requested |
| set_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| ack | input | 1 | Processor acknowledge |
| eoi | input | 1 | End of interrupt |
| tpr_wr | input | 1 | Write task priority |
| tpr_nib | input | 4 | Task-priority class to store |
| spur_wr | input | 1 | Write spurious register |
| spur_data | input | 9 | Spurious register value (bit 8 = enable) |
| rd_sel | input | 3 | Read select code |
| rd_word | input | 3 | 32-bit word index for vector reads |
| rd_data | output | 32 | Read data |
| irq_pending | output | 1 | Interrupt pending towards the processor |
| ack_valid | output | 1 | Acknowledge returned a vector |
| ack_vec | output | 8 | Returned vector |

## Verification
Directed steps first place requests in different 32-bit words and in classes below, equal to and above the task-priority class. This separates real acknowledges from spurious ones and shows where the processor priority switches from the task value to the in-service class. Same-cycle collisions of acknowledge with set-request and with end-of-interrupt show the update order. A long pseudo-random phase then mixes all inputs with occasional init and disable. A behavioural model compares pending, acknowledge and every register read each cycle, which exposes off-by-one class comparisons and wrong-word mappings.

// File: rtl/irqt_pkg.sv
package irqt_pkg;
   localparam int WORD_BITS = 32;
   localparam int CLASS_LSB = 4;

   typedef enum logic [2:0] {
      RD_REQ  = 3'd0,
      RD_SRV  = 3'd1,
      RD_TRG  = 3'd2,
      RD_TPRI = 3'd3,
      RD_PPRI = 3'd4,
      RD_SPUR = 3'd5
   } rd_sel_e;
endpackage

// File: rtl/irqt_msb_find.sv
// Highest-set-bit finder: per-segment encoders, then a segment pick.
module irqt_msb_find #(
   parameter int W   = 256,
   parameter int SEG = 32,
   localparam int IW   = $clog2(W),
   localparam int SW   = $clog2(SEG),
   localparam int NSEG = W / SEG
) (
   input  logic [W-1:0]  bits,
   output logic          found,
   output logic [IW-1:0] idx
);
   logic [NSEG-1:0]    seg_any;
   logic [NSEG*SW-1:0] seg_pos;

   generate
      if ((W % SEG) != 0 || SEG < 2) begin : g_bad_seg
         $error("irqt_msb_find: W must be a multiple of SEG");
      end
      for (genvar g = 0; g < NSEG; g++) begin : g_seg
         logic [SW-1:0] pos;
         always_comb begin
            pos = '0;
            for (int b = 0; b < SEG; b++) begin
               if (bits[g*SEG+b]) pos = SW'(b);
            end
         end
         assign seg_any[g]           = |bits[g*SEG +: SEG];
         assign seg_pos[g*SW +: SW]  = pos;
      end
   endgenerate

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int g = 0; g < NSEG; g++) begin
         if (seg_any[g]) begin
            found = 1'b1;
            idx   = IW'(g*SEG) + IW'(seg_pos[g*SW +: SW]);
         end
      end
   end
endmodule

// File: rtl/irqt_prio.sv
// Processor-priority and decision logic (purely combinational).
module irqt_prio import irqt_pkg::*; #(
   parameter int VW = 8,
   localparam int CW = VW - CLASS_LSB
) (
   input  logic          enable,
   input  logic          irr_found,
   input  logic [VW-1:0] irr_top,
   input  logic          isr_found,
   input  logic [VW-1:0] isr_top,
   input  logic [VW-1:0] tpr,
   output logic [VW-1:0] ppr,
   output logic          pend_next,
   output logic          ack_spur
);
   logic [CW-1:0] isr_cls, tpr_cls, irr_cls, ppr_cls;

   always_comb begin
      isr_cls   = isr_found ? isr_top[VW-1:CLASS_LSB] : '0;
      tpr_cls   = tpr[VW-1:CLASS_LSB];
      ppr       = (isr_cls <= tpr_cls) ? tpr : {isr_cls, {CLASS_LSB{1'b0}}};
      ppr_cls   = ppr[VW-1:CLASS_LSB];
      irr_cls   = irr_top[VW-1:CLASS_LSB];
      pend_next = enable && irr_found && ((ppr == '0) || (irr_cls > ppr_cls));
      ack_spur  = (tpr != '0) && (irr_top <= tpr);
   end
endmodule

// File: rtl/irqt_vec_bank.sv
// Request / in-service / trigger vector storage with ordered updates.
module irqt_vec_bank #(
   parameter int W = 256,
   localparam int IW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init,
   input  logic          set_en,
   input  logic [IW-1:0] set_idx,
   input  logic          set_lvl,
   input  logic          take_en,
   input  logic [IW-1:0] take_idx,
   input  logic          drop_en,
   input  logic [IW-1:0] drop_idx,
   output logic [W-1:0]  irr,
   output logic [W-1:0]  isr,
   output logic [W-1:0]  tmr
);
   logic [W-1:0] set_m, take_m, drop_m;
   logic [W-1:0] irr_n, isr_n, tmr_n;

   always_comb begin
      set_m  = set_en  ? (W'(1) << set_idx)  : '0;
      take_m = take_en ? (W'(1) << take_idx) : '0;
      drop_m = drop_en ? (W'(1) << drop_idx) : '0;
      // acknowledge removes, a new request re-adds: set wins
      irr_n  = (irr & ~take_m) | set_m;
      // end-of-interrupt acts first, acknowledge after
      isr_n  = (isr & ~drop_m) | take_m;
      tmr_n  = tmr;
      if (set_en) tmr_n = set_lvl ? (tmr | set_m) : (tmr & ~set_m);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr <= '0;
         isr <= '0;
         tmr <= '0;
      end else if (init) begin
         irr <= '0;
         isr <= '0;
         tmr <= '0;
      end else begin
         irr <= irr_n;
         isr <= isr_n;
         tmr <= tmr_n;
      end
   end
endmodule

// File: rtl/irq_prio_tracker.sv
module irq_prio_tracker import irqt_pkg::*; #(
   parameter int NUM_VEC = 256,
   localparam int VW  = $clog2(NUM_VEC),
   localparam int CW  = VW - CLASS_LSB,
   localparam int WSW = $clog2(NUM_VEC / WORD_BITS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 init,
   input  logic                 set_req,
   input  logic [VW-1:0]        set_vec,
   input  logic                 set_level,
   input  logic                 ack,
   input  logic                 eoi,
   input  logic                 tpr_wr,
   input  logic [CW-1:0]        tpr_nib,
   input  logic                 spur_wr,
   input  logic [VW:0]          spur_data,
   input  logic [2:0]           rd_sel,
   input  logic [WSW-1:0]       rd_word,
   output logic [WORD_BITS-1:0] rd_data,
   output logic                 irq_pending,
   output logic                 ack_valid,
   output logic [VW-1:0]        ack_vec
);
   localparam int SEG_W = (NUM_VEC >= 256) ? 32 : 16;
   localparam logic [VW:0] SPUR_RST = {1'b0, {VW{1'b1}}};

   generate
      if (NUM_VEC < 64 || (NUM_VEC & (NUM_VEC - 1)) != 0) begin : g_bad_size
         $error("irq_prio_tracker: NUM_VEC must be a power of two, at least 64");
      end
   endgenerate

   logic [NUM_VEC-1:0] irr_vec, isr_vec, tmr_vec;
   logic               irr_found, isr_found;
   logic [VW-1:0]      irr_top, isr_top;
   logic [VW-1:0]      tpr_q, ppr;
   logic [VW:0]        spur_q;
   logic               pend_q, ackv_q, pend_next, ack_spur;
   logic [VW-1:0]      ackvec_q;
   logic               enable, ack_hit, take_en;

   assign enable  = spur_q[VW];
   assign ack_hit = ack && enable && irr_found;
   assign take_en = ack_hit && !ack_spur;

   irqt_msb_find #(.W(NUM_VEC), .SEG(SEG_W)) u_irr_find (
      .bits(irr_vec), .found(irr_found), .idx(irr_top));

   irqt_msb_find #(.W(NUM_VEC), .SEG(SEG_W)) u_isr_find (
      .bits(isr_vec), .found(isr_found), .idx(isr_top));

   irqt_prio #(.VW(VW)) u_prio (
      .enable(enable), .irr_found(irr_found), .irr_top(irr_top),
      .isr_found(isr_found), .isr_top(isr_top), .tpr(tpr_q),
      .ppr(ppr), .pend_next(pend_next), .ack_spur(ack_spur));

   irqt_vec_bank #(.W(NUM_VEC)) u_bank (
      .clk(clk), .rst_n(rst_n), .init(init),
      .set_en(set_req), .set_idx(set_vec), .set_lvl(set_level),
      .take_en(take_en), .take_idx(irr_top),
      .drop_en(eoi && isr_found), .drop_idx(isr_top),
      .irr(irr_vec), .isr(isr_vec), .tmr(tmr_vec));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tpr_q    <= '0;
         spur_q   <= SPUR_RST;
         pend_q   <= 1'b0;
         ackv_q   <= 1'b0;
         ackvec_q <= '0;
      end else if (init) begin
         tpr_q    <= '0;
         spur_q   <= SPUR_RST;
         pend_q   <= 1'b0;
         ackv_q   <= 1'b0;
      end else begin
         if (tpr_wr)  tpr_q  <= {tpr_nib, {CLASS_LSB{1'b0}}};
         if (spur_wr) spur_q <= spur_data;
         pend_q <= pend_next;
         ackv_q <= ack_hit;
         if (ack_hit) ackvec_q <= ack_spur ? spur_q[VW-1:0] : irr_top;
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_sel_e'(rd_sel))
         RD_REQ:  rd_data = irr_vec[int'(rd_word)*WORD_BITS +: WORD_BITS];
         RD_SRV:  rd_data = isr_vec[int'(rd_word)*WORD_BITS +: WORD_BITS];
         RD_TRG:  rd_data = tmr_vec[int'(rd_word)*WORD_BITS +: WORD_BITS];
         RD_TPRI: rd_data = WORD_BITS'(tpr_q);
         RD_PPRI: rd_data = WORD_BITS'(ppr);
         RD_SPUR: rd_data = WORD_BITS'(spur_q);
         default: rd_data = '0;
      endcase
   end

   assign irq_pending = pend_q;
   assign ack_valid   = ackv_q;
   assign ack_vec     = ackvec_q;
endmodule

// File: rtl/irqt_checker.sv
module irqt_checker #(
   parameter int NUM_VEC = 256,
   localparam int VW = $clog2(NUM_VEC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               init,
   input logic               set_req,
   input logic [VW-1:0]      set_vec,
   input logic               set_level,
   input logic               ack,
   input logic               eoi,
   input logic               enable,
   input logic               irr_found,
   input logic [VW-1:0]      irr_top,
   input logic [NUM_VEC-1:0] isr,
   input logic [NUM_VEC-1:0] tmr,
   input logic [VW-1:0]      tpr,
   input logic [VW-1:0]      spur_lo,
   input logic               irq_pending,
   input logic               ack_valid,
   input logic [VW-1:0]      ack_vec
);
   logic masked;
   assign masked = (tpr != '0) && (irr_top <= tpr);

   p_init_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> (isr == '0) && !irq_pending && !ack_valid);

   p_level_sets_trig_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_req && set_level && !init |=> tmr[$past(set_vec)]);

   p_edge_clears_trig_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_req && !set_level && !init |=> !tmr[$past(set_vec)]);

   p_quiet_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !irq_pending);

   p_noack_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ack && !enable |=> !ack_valid);

   p_ack_real_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ack && enable && irr_found && !masked && !init
      |=> ack_valid && (ack_vec == $past(irr_top)));

   p_ack_spur_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack && enable && irr_found && masked && !init && !eoi
      |=> ack_valid && (ack_vec == $past(spur_lo)) && $stable(isr));

   p_ack_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ack && !irr_found |=> !ack_valid);

   p_eoi_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eoi && !ack && !init && (isr != '0)
      |=> $countones(isr) == $past($countones(isr)) - 1);

   p_eoi_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eoi && !ack && !init && (isr == '0) |=> isr == '0);
endmodule

bind irq_prio_tracker irqt_checker #(.NUM_VEC(NUM_VEC)) u_chk (
   .clk(clk), .rst_n(rst_n), .init(init),
   .set_req(set_req), .set_vec(set_vec), .set_level(set_level),
   .ack(ack), .eoi(eoi), .enable(spur_q[VW]),
   .irr_found(irr_found), .irr_top(irr_top),
   .isr(isr_vec), .tmr(tmr_vec), .tpr(tpr_q), .spur_lo(spur_q[VW-1:0]),
   .irq_pending(irq_pending), .ack_valid(ack_valid), .ack_vec(ack_vec));

// File: tb/irq_prio_tracker_test.sv
module irq_prio_tracker_test;
   logic        clk = 1'b0;
   logic        rst_n, init, set_req, set_level, ack, eoi, tpr_wr, spur_wr;
   logic [7:0]  set_vec;
   logic [3:0]  tpr_nib;
   logic [8:0]  spur_data;
   logic [2:0]  rd_sel, rd_word;
   logic [31:0] rd_data;
   logic        irq_pending, ack_valid;
   logic [7:0]  ack_vec;

   always #4 clk = ~clk;   // 125 MHz

   irq_prio_tracker uut (
      .clk(clk), .rst_n(rst_n), .init(init), .set_req(set_req),
      .set_vec(set_vec), .set_level(set_level), .ack(ack), .eoi(eoi),
      .tpr_wr(tpr_wr), .tpr_nib(tpr_nib), .spur_wr(spur_wr),
      .spur_data(spur_data), .rd_sel(rd_sel), .rd_word(rd_word),
      .rd_data(rd_data), .irq_pending(irq_pending),
      .ack_valid(ack_valid), .ack_vec(ack_vec));

   int checks = 0;
   int fails  = 0;
   bit live   = 0;
   bit done   = 0;

   // behavioural reference state
   logic [255:0] m_irr, m_isr, m_tmr;
   logic [7:0]   m_tpr;
   logic [8:0]   m_svr;
   logic         e_pend, e_ackv;
   logic [7:0]   e_ackvec;
   int           m_it, m_is;
   logic [7:0]   m_p;

   function automatic int top_bit(logic [255:0] v);
      for (int i = 255; i >= 0; i--) if (v[i]) return i;
      return -1;
   endfunction

   function automatic logic [7:0] model_ppr();
      int s = top_bit(m_isr);
      int c = (s < 0) ? 0 : (s >> 4);
      if (c <= int'(m_tpr >> 4)) return m_tpr;
      return 8'(c << 4);
   endfunction

   function automatic logic [31:0] model_read(logic [2:0] sel, logic [2:0] w);
      case (sel)
         3'd0: return m_irr[int'(w)*32 +: 32];
         3'd1: return m_isr[int'(w)*32 +: 32];
         3'd2: return m_tmr[int'(w)*32 +: 32];
         3'd3: return {24'd0, m_tpr};
         3'd4: return {24'd0, model_ppr()};
         3'd5: return {23'd0, m_svr};
         default: return 32'd0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n || init) begin
         m_irr = '0; m_isr = '0; m_tmr = '0;
         m_tpr = 8'h00; m_svr = 9'h0FF;
         e_pend = 1'b0; e_ackv = 1'b0;
      end else begin
         m_it = top_bit(m_irr);
         m_is = top_bit(m_isr);
         m_p  = model_ppr();
         e_pend = m_svr[8] && (m_it >= 0) &&
                  ((m_p == 8'h00) || ((m_it >> 4) > int'(m_p >> 4)));
         if (eoi && m_is >= 0) m_isr[m_is] = 1'b0;
         e_ackv = 1'b0;
         if (ack && m_svr[8] && m_it >= 0) begin
            e_ackv = 1'b1;
            if (m_tpr != 8'h00 && m_it <= int'(m_tpr)) begin
               e_ackvec = m_svr[7:0];
            end else begin
               e_ackvec = 8'(m_it);
               m_irr[m_it] = 1'b0;
               m_isr[m_it] = 1'b1;
            end
         end
         if (set_req) begin
            m_irr[set_vec] = 1'b1;
            m_tmr[set_vec] = set_level;
         end
         if (tpr_wr)  m_tpr = {tpr_nib, 4'h0};
         if (spur_wr) m_svr = spur_data;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && live && !done) begin
         chk(irq_pending === e_pend, "R6 pending vs model", 32'(irq_pending), 32'(e_pend));
         chk(ack_valid === e_ackv, "R7 ack_valid vs model", 32'(ack_valid), 32'(e_ackv));
         if (e_ackv)
            chk(ack_vec === e_ackvec, "R8 ack_vec vs model", 32'(ack_vec), 32'(e_ackvec));
      end
   end

   task automatic rchk(input logic [2:0] sel, input logic [2:0] w,
                       input logic [31:0] exp, input string tag);
      rd_sel = sel; rd_word = w;
      #1;
      chk(rd_data === exp, tag, rd_data, exp);
   endtask

   task automatic pulse_set(input logic [7:0] v, input logic lvl);
      @(negedge clk); set_req = 1'b1; set_vec = v; set_level = lvl;
      @(negedge clk); set_req = 1'b0;
   endtask

   task automatic do_ack();
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
   endtask

   task automatic do_eoi();
      @(negedge clk); eoi = 1'b1;
      @(negedge clk); eoi = 1'b0;
   endtask

   task automatic wr_tpr(input logic [3:0] n);
      @(negedge clk); tpr_wr = 1'b1; tpr_nib = n;
      @(negedge clk); tpr_wr = 1'b0;
   endtask

   task automatic wr_spur(input logic [8:0] d);
      @(negedge clk); spur_wr = 1'b1; spur_data = d;
      @(negedge clk); spur_wr = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      checks++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      finish_run();
   end

   logic [31:0] r1 = 32'h1234_5678;
   logic [31:0] r2 = 32'h9E37_79B9;

   initial begin
      rst_n = 0; init = 0; set_req = 0; set_vec = 0; set_level = 0;
      ack = 0; eoi = 0; tpr_wr = 0; tpr_nib = 0; spur_wr = 0;
      spur_data = 0; rd_sel = 0; rd_word = 0;
      repeat (3) @(negedge clk);
      rst_n = 1; live = 1;
      @(negedge clk);

      // R1: reset state
      for (int w = 0; w < 8; w++) begin
         rchk(3'd0, 3'(w), 32'd0, "R1 request word zero");
         rchk(3'd1, 3'(w), 32'd0, "R1 in-service word zero");
         rchk(3'd2, 3'(w), 32'd0, "R1 trigger word zero");
      end
      rchk(3'd3, 3'd0, 32'h00, "R1 task priority zero");
      rchk(3'd5, 3'd0, 32'h0FF, "R1 spurious reset value");
      chk(irq_pending == 1'b0, "R1 pending low", 32'(irq_pending), 32'd0);

      // R3: disabled block records but does not acknowledge
      pulse_set(8'h45, 1'b0);
      do_ack();
      chk(ack_valid == 1'b0, "R3 no vector while disabled", 32'(ack_valid), 32'd0);
      rchk(3'd0, 3'd2, 32'h20, "R2 request bit 0x45 in word 2");
      rchk(3'd1, 3'd2, 32'h00, "R3 in-service unchanged while disabled");
      repeat (2) @(negedge clk);
      chk(irq_pending == 1'b0, "R3 pending low while disabled", 32'(irq_pending), 32'd0);

      // enable: pending rises one cycle after the enable is seen
      wr_spur(9'h12F);
      rchk(3'd5, 3'd0, 32'h12F, "R3 spurious keeps 9 bits");
      chk(irq_pending == 1'b0, "R6 pending lags by a register", 32'(irq_pending), 32'd0);
      @(negedge clk);
      chk(irq_pending == 1'b1, "R6 pending raised", 32'(irq_pending), 32'd1);

      // R2: trigger mode follows the latest request
      pulse_set(8'h81, 1'b1);
      rchk(3'd2, 3'd4, 32'h2, "R2 level sets trigger bit");
      pulse_set(8'h81, 1'b0);
      rchk(3'd2, 3'd4, 32'h0, "R2 edge clears trigger bit");
      rchk(3'd0, 3'd4, 32'h2, "R2 request bit 0x81 in word 4");

      // R7: real acknowledge
      do_ack();
      chk(ack_valid && ack_vec == 8'h81, "R7 acknowledge returns 0x81",
          32'(ack_vec), 32'h81);
      rchk(3'd1, 3'd4, 32'h2, "R7 vector moved to in-service");
      rchk(3'd0, 3'd4, 32'h0, "R7 request bit cleared");
      rchk(3'd4, 3'd0, 32'h80, "R5 priority from in-service class");
      @(negedge clk);
      chk(irq_pending == 1'b0, "R6 lower class blocked", 32'(irq_pending), 32'd0);

      // R4/R5: task priority above in-service class
      wr_tpr(4'h9);
      rchk(3'd3, 3'd0, 32'h90, "R4 task priority shifted");
      rchk(3'd4, 3'd0, 32'h90, "R5 task priority dominates");

      // R8: masked acknowledge returns the spurious vector
      do_ack();
      chk(ack_valid && ack_vec == 8'h2F, "R8 spurious vector returned",
          32'(ack_vec), 32'h2F);
      rchk(3'd0, 3'd2, 32'h20, "R8 request left set");
      rchk(3'd1, 3'd4, 32'h2, "R8 in-service left unchanged");

      // R5 equal classes, then R10
      wr_tpr(4'h8);
      rchk(3'd4, 3'd0, 32'h80, "R5 equal class gives task priority");
      do_eoi();
      rchk(3'd1, 3'd4, 32'h0, "R10 highest in-service cleared");
      wr_tpr(4'h0);
      do_eoi();
      for (int w = 0; w < 8; w++)
         rchk(3'd1, 3'(w), 32'd0, "R10 eoi with nothing in service");

      // R11: acknowledge and set of the same vector
      @(negedge clk); ack = 1; set_req = 1; set_vec = 8'h45; set_level = 0;
      @(negedge clk); ack = 0; set_req = 0;
      chk(ack_vec == 8'h45, "R11 acknowledge with same-cycle set", 32'(ack_vec), 32'h45);
      rchk(3'd0, 3'd2, 32'h20, "R11 same-cycle set wins");
      rchk(3'd1, 3'd2, 32'h20, "R11 vector also in service");
      pulse_set(8'h30, 1'b1);
      @(negedge clk); ack = 1; eoi = 1;
      @(negedge clk); ack = 0; eoi = 0;
      rchk(3'd1, 3'd2, 32'h20, "R11 eoi clears before acknowledge sets");
      rchk(3'd0, 3'd2, 32'h0, "R11 acknowledged request cleared");
      rchk(3'd0, 3'd1, 32'h0001_0000, "R12 vector 0x30 in word 1 bit 16");
      rchk(3'd6, 3'd0, 32'h0, "R12 unused select reads zero");
      rchk(3'd7, 3'd0, 32'h0, "R12 unused select reads zero");

      // R1: init pulse
      @(negedge clk); init = 1; ack = 1; set_req = 1; set_vec = 8'hF0;
      @(negedge clk); init = 0; ack = 0; set_req = 0;
      rchk(3'd0, 3'd1, 32'h0, "R1 init clears requests");
      rchk(3'd0, 3'd7, 32'h0, "R1 init overrides same-cycle set");
      rchk(3'd1, 3'd2, 32'h0, "R1 init clears in-service");
      rchk(3'd2, 3'd1, 32'h0, "R1 init clears trigger");
      rchk(3'd5, 3'd0, 32'h0FF, "R1 init restores spurious");
      chk(ack_valid == 1'b0 && irq_pending == 1'b0, "R1 outputs low after init",
          {30'd0, ack_valid, irq_pending}, 32'd0);

      // R9: acknowledge with nothing requested
      wr_spur(9'h100);
      do_ack();
      chk(ack_valid == 1'b0, "R9 no vector without request", 32'(ack_valid), 32'd0);

      // mixed pseudo-random phase, model-compared every cycle
      for (int n = 0; n < 3000; n++) begin
         @(negedge clk);
         r1 = r1 ^ (r1 << 13); r1 = r1 ^ (r1 >> 17); r1 = r1 ^ (r1 << 5);
         r2 = r2 ^ (r2 << 13); r2 = r2 ^ (r2 >> 17); r2 = r2 ^ (r2 << 5);
         set_req   = r1[0] | r1[1];
         set_vec   = r1[15:8];
         set_level = r1[2];
         ack       = r1[3] & r1[4];
         eoi       = r1[5] & r1[6];
         tpr_wr    = (r1[19:16] == 4'h0);
         tpr_nib   = r1[23:20];
         spur_wr   = (r2[4:0] == 5'h0);
         spur_data = {r2[5] | r2[6], r2[15:8]};
         init      = (r2[22:16] == 7'h0);
         rd_sel    = r2[26:24];
         rd_word   = r2[29:27];
         #1;
         chk(rd_data === model_read(rd_sel, rd_word), "R12 read vs model",
             rd_data, model_read(rd_sel, rd_word));
      end
      @(negedge clk);
      set_req = 0; ack = 0; eoi = 0; tpr_wr = 0; spur_wr = 0; init = 0;
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule